// File: doc/BRIEF.md
# Parallel NOR Flash Write Sequencer

This block sits on the host side of an asynchronous parallel NOR flash and turns a single request into a complete program or erase transaction. A request carries an operation code, a byte address and a data byte. The sequencer first emits the fixed unlock series of bus writes that the flash demands. It then emits the command write, or the target write for a byte program. After that it polls the addressed location until the busy-toggling status bit settles.

Every flash bus cycle is timed in whole clock cycles set by parameters. Write enable has a minimum low width and a minimum high gap. Output enable stays high whenever write enable is low. Address and data are placed one cycle ahead of the write strobe and held past its release. Completion is not trusted on a single agreeing pair of status reads: two extra confirming reads must agree as well. A programmable cycle limit ends a poll that never settles, and the request then ends with an error flag. Each request finishes with a one-cycle done pulse that carries the error flag. The sequencer never starts a new flash command while one is still in progress.

Top module: `flash_wr_seq`

## Requirements
- R1: While reset is applied and after it is released, req_ready is 1, fl_ce_n, fl_we_n and fl_oe_n are 1, fl_dq_oe is 0 and done is 0.
- R2: Operation code 0 (byte program) produces exactly four bus writes in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then req_addr/req_data.
- R3: Every write pulse holds fl_we_n low for at least WE_LO_CYC cycles, with fl_ce_n low and fl_oe_n high throughout. Between consecutive write pulses fl_we_n is high for at least WE_HI_CYC cycles.
- R4: fl_addr and fl_dq_out are stable in the cycle before fl_we_n falls and stay unchanged while fl_we_n is low and in the cycle it returns high.
- R5: Operation code 1 (sector erase) produces six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then req_addr/30h.
- R6: Operation code 2 (chip erase) produces six writes: the same first five as R5, then 5555h/10h.
- R7: After the last write, the block repeatedly reads req_addr with fl_oe_n low for RD_CYC cycles per read. Success is declared on the first read that completes four consecutive reads in which bit 6 agrees from the first to the second read, and the whole byte agrees on each of the two confirming reads. Otherwise polling continues.
- R8: If a status read ends without success once tmo_limit or more cycles have passed since polling began, the request ends with done and err = 1.
- R9: req_ready is 1 only when idle. A request is taken on req_valid && req_ready, and req_ready stays 0 from the cycle after acceptance until the done pulse has passed.
- R10: done is high for exactly one cycle per request. err is 0 on success and is valid in the done cycle.
- R11: Operation code 3 is reserved. It ends with done and err = 1 and produces no write and no read on the flash bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | DW | Byte to program |
| tmo_limit | input | TMO_W | Poll timeout in clock cycles |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Error flag, valid with done |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data drivers |
| fl_dq_in | input | DW | Data returned by the flash |

## Verification
The bench builds the block with WE_LO_CYC=5, WE_HI_CYC=3, RD_CYC=2 and TMO_W=12. The short read cycle lets a scripted flash model return long runs of toggling status within few cycles, including a run with one false agreeing pair that the confirmation reads must reject. The 12-bit limit makes a timeout reachable in about a hundred cycles against a flash that never settles. The unequal low and high widths show whether each strobe phase uses its own parameter.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } fws_op_e;

  // unlock addresses and command bytes of the flash command protocol
  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  CODE_AA     = 8'hAA;
  localparam logic [7:0]  CODE_55     = 8'h55;
  localparam logic [7:0]  CODE_PROG   = 8'hA0;
  localparam logic [7:0]  CODE_ERASE  = 8'h80;
  localparam logic [7:0]  CODE_CHIP   = 8'h10;
  localparam logic [7:0]  CODE_SECT   = 8'h30;

  localparam int unsigned PROG_WRITES  = 4;
  localparam int unsigned ERASE_WRITES = 6;
  localparam int unsigned STEP_W       = 3;

endpackage

// File: rtl/fws_step.sv
module fws_step
  import fws_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  fws_op_e             op,
  input  logic [STEP_W-1:0]   idx,
  input  logic [AW-1:0]       tgt_addr,
  input  logic [DW-1:0]       tgt_data,
  output logic [AW-1:0]       s_addr,
  output logic [DW-1:0]       s_data,
  output logic                s_last
);

  localparam logic [AW-1:0] ADR_A = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] ADR_B = AW'(UNLK_ADDR_B);

  always_comb begin
    s_addr = ADR_A;
    s_data = DW'(CODE_AA);
    if (op == OP_PROG) begin
      s_last = (idx == STEP_W'(PROG_WRITES - 1));
      case (idx)
        3'd0:    begin s_addr = ADR_A;    s_data = DW'(CODE_AA);   end
        3'd1:    begin s_addr = ADR_B;    s_data = DW'(CODE_55);   end
        3'd2:    begin s_addr = ADR_A;    s_data = DW'(CODE_PROG); end
        default: begin s_addr = tgt_addr; s_data = tgt_data;       end
      endcase
    end else begin
      s_last = (idx == STEP_W'(ERASE_WRITES - 1));
      case (idx)
        3'd0:    begin s_addr = ADR_A; s_data = DW'(CODE_AA);    end
        3'd1:    begin s_addr = ADR_B; s_data = DW'(CODE_55);    end
        3'd2:    begin s_addr = ADR_A; s_data = DW'(CODE_ERASE); end
        3'd3:    begin s_addr = ADR_A; s_data = DW'(CODE_AA);    end
        3'd4:    begin s_addr = ADR_B; s_data = DW'(CODE_55);    end
        default: begin
          if (op == OP_CHIP) begin
            s_addr = ADR_A;
            s_data = DW'(CODE_CHIP);
          end else begin
            s_addr = tgt_addr;
            s_data = DW'(CODE_SECT);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fws_bus_phy.sv
module fws_bus_phy #(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int WE_LO_CYC = 4,
  parameter int WE_HI_CYC = 3,
  parameter int RD_CYC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          idle,
  output logic          wr_ack,
  output logic          rd_ack,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe
);

  localparam int MAX_AB = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
  localparam int MAXC   = (MAX_AB > RD_CYC) ? MAX_AB : RD_CYC;
  localparam int CW     = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] LO_LAST = CW'(WE_LO_CYC - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(WE_HI_CYC - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);

  typedef enum logic [2:0] {PH_IDLE, PH_SET, PH_WLO, PH_WHI, PH_RLO} ph_e;

  ph_e           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          ld_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          ce_n_q, we_n_q, oe_n_q, doe_q;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    ld_en  = 1'b0;
    wr_ack = 1'b0;
    rd_ack = 1'b0;
    case (st)
      PH_IDLE: if (start) begin
        ld_en = 1'b1;
        cnt_n = '0;
        st_n  = is_wr ? PH_SET : PH_RLO;
      end
      PH_SET: begin
        cnt_n = '0;
        st_n  = PH_WLO;
      end
      PH_WLO: if (cnt == LO_LAST) begin
        cnt_n = '0;
        st_n  = PH_WHI;
      end else cnt_n = cnt + 1'b1;
      PH_WHI: if (cnt == HI_LAST) begin
        wr_ack = 1'b1;
        st_n   = PH_IDLE;
      end else cnt_n = cnt + 1'b1;
      PH_RLO: if (cnt == RD_LAST) begin
        rd_ack = 1'b1;
        st_n   = PH_IDLE;
      end else cnt_n = cnt + 1'b1;
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      doe_q  <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      ce_n_q <= (st_n == PH_IDLE);
      we_n_q <= (st_n != PH_WLO);
      oe_n_q <= (st_n != PH_RLO);
      doe_q  <= (st_n == PH_SET) || (st_n == PH_WLO) || (st_n == PH_WHI);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (ld_en) begin
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  assign idle     = (st == PH_IDLE);
  assign ce_n     = ce_n_q;
  assign we_n     = we_n_q;
  assign oe_n     = oe_n_q;
  assign bus_addr = addr_q;
  assign bus_dout = data_q;
  assign bus_doe  = doe_q;

endmodule

// File: rtl/fws_poll.sv
module fws_poll #(
  parameter int DW    = 8,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd_ack,
  input  logic [DW-1:0]    rd_byte,
  input  logic [TMO_W-1:0] lim,
  output logic             complete,
  output logic             expired
);

  localparam int          CONFIRM_READS = 2;
  localparam int          AGW           = $clog2(CONFIRM_READS + 2);
  localparam logic [AGW-1:0] AG_DONE    = AGW'(CONFIRM_READS);
  localparam int          TOG_BIT       = 6;

  logic             have_prev, have_prev_n;
  logic [DW-1:0]    prev, prev_n;
  logic [AGW-1:0]   agree, agree_n;
  logic [TMO_W-1:0] tcnt, tcnt_n;
  logic             match;

  // first agreement is on the toggle bit, confirmations need the whole byte
  always_comb begin
    if (agree == '0) match = have_prev && (rd_byte[TOG_BIT] == prev[TOG_BIT]);
    else             match = have_prev && (rd_byte == prev);
  end

  assign complete = rd_ack && match && (agree == AG_DONE);
  assign expired  = (tcnt >= lim);

  always_comb begin
    have_prev_n = have_prev;
    prev_n      = prev;
    agree_n     = agree;
    tcnt_n      = tcnt;
    if (clr) begin
      have_prev_n = 1'b0;
      agree_n     = '0;
      tcnt_n      = '0;
    end else begin
      if (tcnt != {TMO_W{1'b1}}) tcnt_n = tcnt + 1'b1;
      if (rd_ack) begin
        have_prev_n = 1'b1;
        prev_n      = rd_byte;
        agree_n     = match ? agree + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev      <= '0;
      agree     <= '0;
      tcnt      <= '0;
    end else begin
      have_prev <= have_prev_n;
      prev      <= prev_n;
      agree     <= agree_n;
      tcnt      <= tcnt_n;
    end
  end

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import fws_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int WE_LO_CYC = 4,
  parameter int WE_HI_CYC = 3,
  parameter int RD_CYC    = 2,
  parameter int TMO_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             done,
  output logic             err,
  output logic             fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic [AW-1:0]    fl_addr,
  output logic [DW-1:0]    fl_dq_out,
  output logic             fl_dq_oe,
  input  logic [DW-1:0]    fl_dq_in
);

  typedef enum logic [1:0] {T_IDLE, T_WRITE, T_POLL, T_DONE} top_e;

  top_e              st, st_n;
  fws_op_e           op_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic [STEP_W-1:0] step_q, step_n;
  logic              err_q, err_n;
  logic              ld_en;

  logic [AW-1:0] s_addr, phy_addr;
  logic [DW-1:0] s_data;
  logic          s_last;
  logic          phy_idle, phy_start, wr_ack, rd_ack;
  logic          complete, expired, poll_clr;

  fws_step #(.AW(AW), .DW(DW)) u_step (
    .op       (op_q),
    .idx      (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .s_addr   (s_addr),
    .s_data   (s_data),
    .s_last   (s_last)
  );

  assign phy_start = phy_idle && ((st == T_WRITE) || (st == T_POLL));
  assign phy_addr  = (st == T_WRITE) ? s_addr : addr_q;

  fws_bus_phy #(
    .AW(AW), .DW(DW), .WE_LO_CYC(WE_LO_CYC), .WE_HI_CYC(WE_HI_CYC), .RD_CYC(RD_CYC)
  ) u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (phy_start),
    .is_wr    (st == T_WRITE),
    .addr     (phy_addr),
    .wdata    (s_data),
    .idle     (phy_idle),
    .wr_ack   (wr_ack),
    .rd_ack   (rd_ack),
    .ce_n     (fl_ce_n),
    .we_n     (fl_we_n),
    .oe_n     (fl_oe_n),
    .bus_addr (fl_addr),
    .bus_dout (fl_dq_out),
    .bus_doe  (fl_dq_oe)
  );

  assign poll_clr = (st != T_POLL);

  fws_poll #(.DW(DW), .TMO_W(TMO_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (poll_clr),
    .rd_ack   (rd_ack),
    .rd_byte  (fl_dq_in),
    .lim      (tmo_limit),
    .complete (complete),
    .expired  (expired)
  );

  always_comb begin
    st_n   = st;
    step_n = step_q;
    err_n  = err_q;
    ld_en  = 1'b0;
    case (st)
      T_IDLE: if (req_valid) begin
        ld_en  = 1'b1;
        step_n = '0;
        if (fws_op_e'(req_op) == OP_RSVD) begin
          err_n = 1'b1;
          st_n  = T_DONE;
        end else begin
          err_n = 1'b0;
          st_n  = T_WRITE;
        end
      end
      T_WRITE: if (wr_ack) begin
        if (s_last) st_n = T_POLL;
        else        step_n = step_q + 1'b1;
      end
      T_POLL: if (rd_ack) begin
        if (complete) begin
          err_n = 1'b0;
          st_n  = T_DONE;
        end else if (expired) begin
          err_n = 1'b1;
          st_n  = T_DONE;
        end
      end
      T_DONE:  st_n = T_IDLE;
      default: st_n = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      step_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st     <= st_n;
      step_q <= step_n;
      err_q  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (ld_en) begin
      op_q   <= fws_op_e'(req_op);
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign req_ready = (st == T_IDLE);
  assign done      = (st == T_DONE);
  assign err       = (st == T_DONE) && err_q;

endmodule

// File: rtl/fws_chk.sv
module fws_chk #(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int WE_LO_CYC = 4,
  parameter int WE_HI_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out
);

  logic [15:0] lo_cnt, hi_cnt;
  logic        seen_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt     <= '0;
      hi_cnt     <= '0;
      seen_pulse <= 1'b0;
    end else begin
      if (!fl_we_n) begin
        if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
        hi_cnt <= '0;
      end else begin
        lo_cnt <= '0;
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      end
      if (!fl_we_n) seen_pulse <= 1'b1;
    end
  end

  p_oe_high_we_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_oe_n && !fl_ce_n));

  p_we_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (lo_cnt >= 16'(WE_LO_CYC)));

  p_we_high_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_we_n) && seen_pulse) |-> (hi_cnt >= 16'(WE_HI_CYC)));

  p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> ($stable(fl_addr) && $stable(fl_dq_out)));

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready ##1 (!done && req_ready));

endmodule

bind flash_wr_seq fws_chk #(
  .AW(AW), .DW(DW), .WE_LO_CYC(WE_LO_CYC), .WE_HI_CYC(WE_HI_CYC)
) u_fws_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .fl_ce_n   (fl_ce_n),
  .fl_we_n   (fl_we_n),
  .fl_oe_n   (fl_oe_n),
  .fl_addr   (fl_addr),
  .fl_dq_out (fl_dq_out)
);

// File: tb/test_flash_wr_seq.sv
module test_flash_wr_seq;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int LO = 5;
  localparam int HI = 3;
  localparam int RD = 2;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] tmo_limit = '0;
  logic          done, err;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;
  logic [DW-1:0] dq_drv = '0;

  always #5 clk = ~clk;

  flash_wr_seq #(
    .AW(AW), .DW(DW), .WE_LO_CYC(LO), .WE_HI_CYC(HI), .RD_CYC(RD), .TMO_W(TW)
  ) i_flash_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .tmo_limit(tmo_limit),
    .done(done), .err(err), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(dq_drv)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } wr_t;
  wr_t wq[$];

  // scripted flash model state
  int            busy_n, glitch_k, rd_idx, exp_reads, lo_cnt, hi_cnt;
  bit            exp_err, op_done, pulse_seen, bad_lo, wd_hit;
  bit            prev_we = 1'b1, prev_oe = 1'b1;
  string         cur_tag = "R2";
  logic [AW-1:0] poll_addr;

  function automatic bit dq6_at(input int n);
    if (n < busy_n) begin
      if (n == glitch_k && n > 0) return 1'((n - 1) & 1);
      return 1'(n & 1);
    end
    return 1'b1;
  endfunction

  function automatic int reads_needed();
    for (int n = 3; n < 100000; n++)
      if (dq6_at(n) == dq6_at(n-1) && dq6_at(n-1) == dq6_at(n-2) && dq6_at(n-2) == dq6_at(n-3))
        return n + 1;
    return -1;
  endfunction

  // monitor: pops expected writes, measures strobes, serves status reads
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_oe && !fl_oe_n) begin
        dq_drv    = '0;
        dq_drv[6] = dq6_at(rd_idx);
        chk(fl_addr == poll_addr, "R7 status read address", fl_addr, poll_addr);
        rd_idx++;
      end
      if (!fl_we_n) begin
        lo_cnt++;
        if (!fl_oe_n || fl_ce_n) bad_lo = 1'b1;
      end
      if (prev_we && !fl_we_n && pulse_seen)
        chk(hi_cnt >= HI, "R3 high gap between pulses", hi_cnt, HI);
      if (!prev_we && fl_we_n) begin
        chk(lo_cnt >= LO, "R3 write enable low width", lo_cnt, LO);
        chk(!bad_lo, "R3 oe high and ce low during pulse", bad_lo, 0);
        if (wq.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected write"}, fl_addr, 0);
        end else begin
          wr_t e;
          e = wq.pop_front();
          chk(fl_addr == e.a, {cur_tag, " write address"}, fl_addr, e.a);
          chk(fl_dq_out == e.d, {cur_tag, " write data"}, fl_dq_out, e.d);
        end
        pulse_seen = 1'b1;
        lo_cnt = 0;
        hi_cnt = 0;
        bad_lo = 1'b0;
      end
      if (fl_we_n) hi_cnt++;
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
      if (done) begin
        chk(err == exp_err, "R10 err flag at done", err, exp_err);
        if (exp_reads >= 0)
          chk(rd_idx == exp_reads, "R7 status reads before done", rd_idx, exp_reads);
        chk(wq.size() == 0, {cur_tag, " all writes issued"}, wq.size(), 0);
        op_done = 1'b1;
      end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_t e;
    e.a = a;
    e.d = d;
    wq.push_back(e);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy, input int gk, input int lim, input bit eerr,
                        input string tag);
    busy_n = busy; glitch_k = gk; rd_idx = 0; exp_err = eerr; cur_tag = tag;
    poll_addr = a; op_done = 1'b0; pulse_seen = 1'b0;
    if (op != 2'd3) begin
      push(19'h05555, 8'hAA);
      push(19'h02AAA, 8'h55);
      if (op == 2'd0) begin
        push(19'h05555, 8'hA0);
        push(a, d);
      end else begin
        push(19'h05555, 8'h80);
        push(19'h05555, 8'hAA);
        push(19'h02AAA, 8'h55);
        if (op == 2'd2) push(19'h05555, 8'h10);
        else            push(a, 8'h30);
      end
    end
    if (op == 2'd3) exp_reads = 0;
    else if (eerr)  exp_reads = -1;
    else            exp_reads = reads_needed();
    @(posedge clk); #2;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; tmo_limit = TW'(lim);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
    while (!op_done && !wd_hit) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    wd_hit = 1'b1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready during reset", req_ready, 1);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high during reset",
        {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high after reset",
        {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(!fl_dq_oe && !done, "R1 drivers off and done low", {fl_dq_oe, done}, 0);

    // R2 program, short busy time
    run_op(2'd0, 19'h1234A, 8'h5C, 6, -1, 4095, 1'b0, "R2");
    // R5 sector erase
    run_op(2'd1, 19'h7A000, 8'h00, 9, -1, 4095, 1'b0, "R5");
    // R6 chip erase, device settles at once
    run_op(2'd2, 19'h00010, 8'h00, 0, -1, 4095, 1'b0, "R6");
    // R7 false agreeing pair must be rejected by confirmation reads
    run_op(2'd0, 19'h00ABC, 8'hE1, 10, 5, 4095, 1'b0, "R7");
    // R11 reserved code: no bus activity, error
    run_op(2'd3, 19'h00001, 8'h11, 0, -1, 4095, 1'b1, "R11");
    chk(fl_ce_n == 1'b1, "R11 chip enable idle", fl_ce_n, 1);
    // R8 timeout: device never settles
    run_op(2'd0, 19'h3FFFF, 8'h77, 1 << 30, -1, 100, 1'b1, "R8");
    // recovery after timeout
    run_op(2'd1, 19'h01000, 8'h00, 4, -1, 4095, 1'b0, "R5");

    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && !done, "R10 idle after last done", {req_ready, done}, 2'b10);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule